// File: doc/BRIEF.md
# Serial debug register access port

This block sits inside a memory controller and lets a debug host reach a handful of internal registers over a few slow wires. The wires are a serial input, a serial output, a shift clock, an address strobe, an execute strobe and an active-low debug reset. All state in the block is clocked on the rising edge of the shift clock.

To reach a register, the host raises the address strobe and shifts in a 16-bit select word, most significant bit first. The upper 13 bits are a device prefix and the lower 3 bits are a register number. When the prefix names this device, the host can do one of two things. For a read, it pulses execute for one shift cycle, which loads the chosen register, and then clocks the bits out LSB first. For a write, it keeps execute low and shifts new data in.

There are three registers: a fixed identification word, a 10-bit configuration register that software can write, and a 44-bit error capture register built from inputs. Register numbers 3 to 7 read as zero.

Top module: `dbgp_top`

## Requirements
- R1: While the address strobe is high, each rising shift-clock edge shifts the serial input into the select word, most significant bit first. The last 16 bits shifted form the select: bits 15..3 are the prefix and bits 2..0 are the register number. With the strobe low, the select word is held.
- R2: The port responds only when the prefix equals 0x020. On any other prefix, serial out stays low, an execute pulse loads nothing, and shifted data leaves the configuration register unchanged.
- R3: Register 0 is read-only and reads 0x5180. Bits 15..12 hold a header of 5, bits 11..6 hold a type of 6, and bits 5..0 hold a version of 0.
- R4: Take the first edge after selection with execute high. That edge loads the selected register and puts its bit 0 on serial out. Each later edge puts the next higher bit out. Once the register's width is exhausted, serial out is low.
- R5: Register 1 is a 10-bit writable register, and its value is shown on the configuration output. After selection, with execute low, the first data bit shifted in lands in bit 0. The register can also be read back through R4.
- R6: A write takes effect on the edge that carries its 10th data bit. Until then the register keeps its old value. Bits after the 10th, and an incomplete write cut off by a new address strobe, change nothing.
- R7: Register 2 is a 44-bit read-only error capture word. Bits 31..0 hold the error address, bits 36..32 hold the error status, and bits 43..37 hold the syndrome.
- R8: Serial out is low except while a matched register is being read out, including the whole time the address strobe is high.
- R9: Debug reset low clears the select word, the matched flag and any read in progress, and returns the configuration register to zero. It acts at once, without waiting for a clock edge.
- R10: Register numbers 3 to 7 read as all zeros. Write data shifted into registers 0, 2 and 3 to 7 leaves the configuration register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n_i | input | 1 | Active-low debug reset, asynchronous |
| sin_i | input | 1 | Serial data and select input |
| addr_stb_i | input | 1 | High while the select word is shifted in |
| exec_stb_i | input | 1 | High for one shift cycle to load a register for reading |
| err_addr_i | input | 32 | Captured error address |
| err_stat_i | input | 5 | Captured error status |
| err_syn_i | input | 7 | Captured error syndrome |
| sout_o | output | 1 | Serial register output |
| cfg_o | output | 10 | Current value of the writable register |

## Verification
Some internal faults only become visible once a read has started. A wrong select word or matched flag shows up on the first shift cycle after an execute pulse: serial out then carries the wrong register's bit 0, or stays low when it should not. A shift register that is off by one position shows up as a one-cycle slip, which the bench catches by comparing every bit of the 16-bit and 44-bit reads and the trailing zeros after them. A write counter error appears on the configuration output in the very cycle the 10th bit arrives, or in one of the nine cycles before it.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int PFX_W     = 13;
  localparam int NUM_W     = 3;
  localparam logic [PFX_W-1:0] DEV_PREFIX = 13'h020;
  localparam int ID_W      = 16;
  localparam int CFG_W     = 10;
  localparam int EA_W      = 32;
  localparam int ES_W      = 5;
  localparam int SYN_W     = 7;
  localparam int ERR_W     = EA_W + ES_W + SYN_W;
  localparam int NREG      = 1 << NUM_W;
  localparam logic [3:0] ID_HDR  = 4'd5;
  localparam logic [5:0] ID_TYPE = 6'd6;
  localparam logic [5:0] ID_VER  = 6'd0;

  function automatic logic [ID_W-1:0] id_word();
    return {ID_HDR, ID_TYPE, ID_VER};
  endfunction

  function automatic logic [ERR_W-1:0] err_word(input logic [EA_W-1:0] a,
                                                input logic [ES_W-1:0] s,
                                                input logic [SYN_W-1:0] y);
    return {y, s, a};
  endfunction
endpackage

// File: rtl/dbgp_sel.sv
module dbgp_sel #(
  parameter int PFX_W = 13,
  parameter int NUM_W = 3,
  parameter logic [PFX_W-1:0] PREFIX = 13'h020
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sin,
  input  logic             stb,
  output logic             matched,
  output logic [NUM_W-1:0] regno
);
  localparam int SEL_W = PFX_W + NUM_W;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             match_q;

  assign sel_d = {sel_q[SEL_W-2:0], sin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      match_q <= 1'b0;
    end else if (stb) begin
      sel_q   <= sel_d;
      match_q <= (sel_d[SEL_W-1:NUM_W] == PREFIX);
    end
  end

  assign matched = match_q;
  assign regno   = sel_q[NUM_W-1:0];

  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (sel_q[0] == $past(sin)));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(regno) && $stable(matched)));
  a_r2_match_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    matched |-> (sel_q[SEL_W-1:NUM_W] == PREFIX));
endmodule

// File: rtl/dbgp_wr.sv
module dbgp_wr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sin,
  input  logic         en,
  input  logic         clear,
  output logic [W-1:0] val,
  output logic         commit
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  wbuf_q;
  logic [W-1:0]  wbuf_d;
  logic [W-1:0]  val_q;
  logic [CW-1:0] cnt_q;

  assign wbuf_d = {sin, wbuf_q[W-1:1]};
  assign commit = en && !clear && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q <= '0;
      cnt_q  <= '0;
      val_q  <= '0;
    end else if (clear) begin
      cnt_q  <= '0;
    end else if (en && (cnt_q != CW'(W))) begin
      wbuf_q <= wbuf_d;
      cnt_q  <= cnt_q + 1'b1;
      if (commit) val_q <= wbuf_d;
    end
  end

  assign val = val_q;

  a_r6_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt_q == CW'(W)));
  a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CW'(W - 1)) |=> $stable(val));
endmodule

// File: rtl/dbgp_rd.sv
module dbgp_rd #(
  parameter int RD_W  = 44,
  parameter int NREG  = 8,
  parameter int NUM_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       load,
  input  logic [NUM_W-1:0]           regno,
  input  logic [NREG-1:0][RD_W-1:0]  regs,
  output logic                       sout,
  output logic                       active
);
  logic [RD_W-1:0] sh_q;
  logic            act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (clear) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      sh_q  <= regs[regno];
      act_q <= 1'b1;
    end else if (act_q) begin
      sh_q  <= sh_q >> 1;
    end
  end

  assign active = act_q;
  assign sout   = act_q & sh_q[0];

  a_r4_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> active);
  a_r4_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (sout == $past(regs[regno][0])));
  a_r8_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !sout);
endmodule

// File: rtl/dbgp_top.sv
module dbgp_top
  import dbgp_pkg::*;
#(
  parameter int CFG_BITS = CFG_W,
  parameter int EADDR_W  = EA_W,
  parameter int ESTAT_W  = ES_W,
  parameter int ESYN_W   = SYN_W
) (
  input  logic                sclk_i,
  input  logic                rst_n_i,
  input  logic                sin_i,
  input  logic                addr_stb_i,
  input  logic                exec_stb_i,
  input  logic [EADDR_W-1:0]  err_addr_i,
  input  logic [ESTAT_W-1:0]  err_stat_i,
  input  logic [ESYN_W-1:0]   err_syn_i,
  output logic                sout_o,
  output logic [CFG_BITS-1:0] cfg_o
);
  localparam int EW   = EADDR_W + ESTAT_W + ESYN_W;
  localparam int RD_W = (EW > ID_W) ? ((EW > CFG_BITS) ? EW : CFG_BITS)
                                    : ((ID_W > CFG_BITS) ? ID_W : CFG_BITS);

  logic             matched;
  logic [NUM_W-1:0] regno;
  logic             rd_load;
  logic             rd_active;
  logic             wr_en;
  logic             wr_commit;
  logic [CFG_BITS-1:0] cfg_val;
  logic [NREG-1:0][RD_W-1:0] regs;

  dbgp_sel #(.PFX_W(PFX_W), .NUM_W(NUM_W), .PREFIX(DEV_PREFIX)) u_sel (
    .clk(sclk_i), .rst_n(rst_n_i), .sin(sin_i), .stb(addr_stb_i),
    .matched(matched), .regno(regno));

  assign rd_load = matched && exec_stb_i && !addr_stb_i;
  assign wr_en   = matched && !addr_stb_i && !exec_stb_i && !rd_active
                   && (regno == NUM_W'(1));

  dbgp_wr #(.W(CFG_BITS)) u_wr (
    .clk(sclk_i), .rst_n(rst_n_i), .sin(sin_i), .en(wr_en),
    .clear(addr_stb_i), .val(cfg_val), .commit(wr_commit));

  for (genvar i = 0; i < NREG; i++) begin : g_regs
    if (i == 0) begin : g_id
      assign regs[i] = {{(RD_W-ID_W){1'b0}}, id_word()};
    end else if (i == 1) begin : g_cfg
      assign regs[i] = {{(RD_W-CFG_BITS){1'b0}}, cfg_val};
    end else if (i == 2) begin : g_err
      assign regs[i] = {{(RD_W-EW){1'b0}}, err_syn_i, err_stat_i, err_addr_i};
    end else begin : g_zero
      assign regs[i] = '0;
    end
  end

  dbgp_rd #(.RD_W(RD_W), .NREG(NREG), .NUM_W(NUM_W)) u_rd (
    .clk(sclk_i), .rst_n(rst_n_i), .clear(addr_stb_i), .load(rd_load),
    .regno(regno), .regs(regs), .sout(sout_o), .active(rd_active));

  assign cfg_o = cfg_val;

  a_r2_unmatched_quiet: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
    !matched |=> !sout_o);
  a_r6_read_keeps_cfg: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
    rd_active |=> $stable(cfg_o));
  a_r8_strobe_quiet: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
    addr_stb_i |=> !sout_o);
  a_r10_other_regs: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
    (regno != NUM_W'(1)) |=> $stable(cfg_o));
  a_r5_commit_only_sel: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
    wr_commit |-> (matched && regno == NUM_W'(1)));
endmodule

// File: tb/dbgp_top_tb_top.sv
module dbgp_top_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int Q = CLK_PERIOD / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sin = 1'b0, astb = 1'b0, exec = 1'b0;
  logic [31:0] eaddr = 32'h0;
  logic [4:0]  estat = 5'h0;
  logic [6:0]  esyn  = 7'h0;
  logic sout;
  logic [9:0] cfg;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgp_top dut_i (
    .sclk_i(clk), .rst_n_i(rst_n), .sin_i(sin), .addr_stb_i(astb),
    .exec_stb_i(exec), .err_addr_i(eaddr), .err_stat_i(estat),
    .err_syn_i(esyn), .sout_o(sout), .cfg_o(cfg));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares serial out against scoreboard entries
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {63'd0, sout}, {63'd0, e});
    end
  end

  task automatic step(input logic s, input logic a, input logic e,
                      input bit chk, input bit expv, input string tag);
    sin = s; astb = a; exec = e;
    @(posedge clk);
    #(Q);
    if (chk) begin
      exp_q.push_back(expv);
      tag_q.push_back(tag);
    end
  endtask

  task automatic select(input logic [12:0] pfx, input logic [2:0] num);
    logic [15:0] v;
    v = {pfx, num};
    for (int i = 15; i >= 0; i--) step(v[i], 1'b1, 1'b0, 1, 0, "R8 R1 select");
  endtask

  task automatic read_reg(input logic [12:0] pfx, input logic [2:0] num,
                          input int width, input logic [63:0] value, input string tag);
    select(pfx, num);
    step(1'b0, 1'b0, 1'b1, 1, value[0], tag);
    for (int i = 1; i < width; i++) step(1'b0, 1'b0, 1'b0, 1, value[i], tag);
    step(1'b0, 1'b0, 1'b0, 1, 0, "R4 past width");
    step(1'b0, 1'b0, 1'b0, 1, 0, "R4 past width");
  endtask

  task automatic write_bits(input logic [12:0] pfx, input logic [2:0] num,
                            input int n, input logic [15:0] value);
    select(pfx, num);
    for (int i = 0; i < n; i++) step(value[i], 1'b0, 1'b0, 1, 0, "R8 write quiet");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] idv;
    logic [43:0] errv;
    idv = 16'(5 * 4096 + 6 * 64 + 0);
    repeat (3) @(posedge clk);
    #(Q);
    check("R9 reset cfg", {54'd0, cfg}, 64'd0);
    check("R9 reset sout", {63'd0, sout}, 64'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "");

    // R3 R4: identification word
    read_reg(13'h020, 3'd0, 16, {48'd0, idv}, "R3 R4 id read");
    check("R3 id value", {48'd0, idv}, 64'h5180);

    // R5 R6: write register 1 bit by bit
    select(13'h020, 3'd1);
    for (int i = 0; i < 10; i++) begin
      logic [9:0] w;
      w = 10'h2A5;
      step(w[i], 0, 0, 0, 0, "");
      check(i == 9 ? "R5 write commit" : "R6 partial write",
            {54'd0, cfg}, (i == 9) ? 64'h2A5 : 64'h0);
    end
    read_reg(13'h020, 3'd1, 10, 64'h2A5, "R5 readback");

    // R6: extra bits ignored; first 10 bits land
    write_bits(13'h020, 3'd1, 12, 16'hF0C3);
    check("R6 extra bits ignored", {54'd0, cfg}, 64'h0C3);

    // R6: interrupted write
    write_bits(13'h020, 3'd1, 5, 16'h001F);
    select(13'h020, 3'd0);
    check("R6 cut-off write", {54'd0, cfg}, 64'h0C3);

    // R7: error capture layout
    eaddr = 32'h0000_00F0; estat = 5'd3; esyn = 7'd62;
    errv = 44'(62) << 37 | 44'(3) << 32 | 44'h0F0;
    read_reg(13'h020, 3'd2, 44, {20'd0, errv}, "R7 error word");
    eaddr = 32'hA5C3_0F1E; estat = 5'd9; esyn = 7'h55;
    errv = {7'h55, 5'd9, 32'hA5C3_0F1E};
    read_reg(13'h020, 3'd2, 44, {20'd0, errv}, "R7 error word 2");

    // R2: wrong prefix
    read_reg(13'h021, 3'd0, 16, 64'd0, "R2 wrong prefix read");
    write_bits(13'h120, 3'd1, 10, 16'h3FF);
    check("R2 wrong prefix write", {54'd0, cfg}, 64'h0C3);

    // R10: unimplemented and read-only registers
    read_reg(13'h020, 3'd5, 16, 64'd0, "R10 reg5 zero");
    read_reg(13'h020, 3'd7, 16, 64'd0, "R10 reg7 zero");
    write_bits(13'h020, 3'd0, 10, 16'h155);
    check("R10 write reg0 ignored", {54'd0, cfg}, 64'h0C3);
    write_bits(13'h020, 3'd3, 10, 16'h2AA);
    check("R10 write reg3 ignored", {54'd0, cfg}, 64'h0C3);
    read_reg(13'h020, 3'd0, 16, {48'd0, idv}, "R3 id after writes");

    // R9: reset in the middle of a write
    write_bits(13'h020, 3'd1, 4, 16'hF);
    rst_n = 1'b0;
    #1;
    check("R9 async reset cfg", {54'd0, cfg}, 64'd0);
    check("R9 async reset sout", {63'd0, sout}, 64'd0);
    @(posedge clk); #(Q);
    rst_n = 1'b1;
    step(0, 0, 1, 1, 0, "R9 match cleared");
    for (int i = 0; i < 10; i++) step(1'b1, 0, 0, 1, 0, "R9 no read");
    check("R9 no write after reset", {54'd0, cfg}, 64'd0);

    step(0, 0, 0, 0, 0, "");
    @(negedge clk); #1;
    check("scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule